// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical pixel counters of a raster display and, from them, the blank, horizontal sync, vertical sync and active-video strobes. Every boundary of the raster comes from a small register file reached over a single-cycle write/read port. Each axis has three timing words. Each word packs a lower boundary in bits 15:0 and an upper boundary in bits 31:16, and every field holds its count minus one. A control word holds the run enable, the two sync polarities, an immediate-update bit and a three-bit power mode.

Writes to any register other than the lock register are dropped until the unlock key is written to the lock register. Any other value written there locks the file again. Timing words go into a shadow copy first. The counters use them from the next frame boundary, unless immediate update is on or the generator is stopped. The power mode forces blanking and gates each sync separately. A DAC power-down output is raised whenever either sync is gated off.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset both counters read 0, the register file is locked, the control word is 0, and so the outputs are hsync_o=1, vsync_o=1, blank_o=0, active_o=0 and dac_pd_o=0. A read of address 0 returns 0.
- R2: At address 0, writing 0x0000_4758 unlocks the register file and writing any other value locks it. A read of address 0 returns 1 when the file is unlocked. While the file is locked, writes to addresses 1 to 7 leave those registers unchanged.
- R3: Address 1 is control: bit 0 enable, bit 1 hsync polarity, bit 2 vsync polarity, bit 3 immediate update, bits 6:4 power mode. Addresses 2, 3 and 4 hold the horizontal active/total, blank start/end and sync start/end words. Addresses 5, 6 and 7 hold the same three words for the vertical axis. Each word has its low field in [15:0] and its high field in [31:16], and a read returns the last accepted write.
- R4: While enabled, the horizontal counter steps every cycle and returns to 0 after reaching the total field. The vertical counter steps only on a horizontal wrap and returns to 0 after reaching its total field.
- R5: active_o is 1 when the generator is enabled, the power mode is 0, hcount is at most the horizontal active field, and vcount is at most the vertical active field.
- R6: blank_o is 1 when the generator is enabled and either counter lies above its blank start field and at or below its blank end field.
- R7: A sync is in its window when its counter lies above its sync start field and at or below its sync end field. Its output equals the window when the polarity bit is 1 and the inverse of the window when the bit is 0.
- R8: The power modes are: 0 normal; 1 blank forced; 2 blank forced with vsync gated off; 3 blank forced with hsync gated off; 4 to 7 blank forced with both syncs gated off. A gated sync holds its inactive level.
- R9: dac_pd_o is 1 unless the power mode leaves both syncs enabled (modes 0 and 1).
- R10: While enable is 0, both counters are 0, blank_o and active_o are 0, and each sync sits at its inactive level.
- R11: A timing word written while running takes effect at the next frame start, which is the wrap of both counters. When immediate update is set, it takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| hcount_o | output | 16 | Horizontal pixel counter |
| vcount_o | output | 16 | Vertical line counter |
| hsync_o | output | 1 | Horizontal sync, polarity per control |
| vsync_o | output | 1 | Vertical sync, polarity per control |
| blank_o | output | 1 | Blanking interval |
| active_o | output | 1 | Active video region |
| dac_pd_o | output | 1 | DAC power-down request |

## Verification
On every cycle, the assertions check the following. A counter returns to zero after a wrap and holds still when it is not stepped. A stopped generator clears its counters and quietens its outputs. A locked write leaves the register file unchanged. The live timing copy holds between frame boundaries when immediate update is off. The power-off mode and DAC power-down leave the syncs at their inactive levels. Only the bench scenarios can show the raster geometry itself: the exact pixel and line where each window opens and closes, the effect of each polarity setting, the register readback, and the one-frame delay of a total change compared with its immediate application.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NTIM   = 6;
  localparam int unsigned CTRL_W = 7;

  localparam logic [ADDR_W-1:0] A_LOCK = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_TIM0 = 3'd2;

  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_HPOL = 1;
  localparam int unsigned C_VPOL = 2;
  localparam int unsigned C_IMM  = 3;
  localparam int unsigned C_MODE = 4;

  localparam logic [2:0] PM_ON    = 3'd0;
  localparam logic [2:0] PM_BLANK = 3'd1;
  localparam logic [2:0] PM_NO_VS = 3'd2;
  localparam logic [2:0] PM_NO_HS = 3'd3;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs import disp_timing_pkg::*; #(
  parameter int unsigned       DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY    = 'h4758
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic                        frame_end_i,
  output logic [NTIM-1:0][DATA_W-1:0] tim_o,
  output logic                        en_o,
  output logic                        hpol_o,
  output logic                        vpol_o,
  output logic [2:0]                  mode_o
);
  logic                        unlocked_q;
  logic [CTRL_W-1:0]           ctrl_q;
  logic [NTIM-1:0][DATA_W-1:0] shadow_q, active_q;
  logic [ADDR_W-1:0]           idx;
  logic                        load;

  assign idx  = addr_i - A_TIM0;
  assign load = ctrl_q[C_IMM] || !ctrl_q[C_EN] || frame_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      ctrl_q     <= '0;
      shadow_q   <= '0;
      active_q   <= '0;
    end else begin
      if (we_i) begin
        if (addr_i == A_LOCK)     unlocked_q <= (wdata_i == KEY);
        else if (unlocked_q) begin
          if (addr_i == A_CTRL)   ctrl_q <= wdata_i[CTRL_W-1:0];
          else                    shadow_q[idx] <= wdata_i;
        end
      end
      if (load) active_q <= shadow_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LOCK:  rdata_o[0] = unlocked_q;
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      default: rdata_o = shadow_q[idx];
    endcase
  end

  assign tim_o  = active_q;
  assign en_o   = ctrl_q[C_EN];
  assign hpol_o = ctrl_q[C_HPOL];
  assign vpol_o = ctrl_q[C_VPOL];
  assign mode_o = ctrl_q[C_MODE +: 3];

  assert_locked_write_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlocked_q && addr_i != A_LOCK) |=> ($stable(shadow_q) && $stable(ctrl_q)));

  assert_shadow_deferred_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[C_EN] && !ctrl_q[C_IMM] && !frame_end_i) |=> $stable(active_q));
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
  parameter int unsigned FIELD_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               step_i,
  input  logic [FIELD_W-1:0] tot_i,
  input  logic [FIELD_W-1:0] act_i,
  input  logic [FIELD_W-1:0] blk_s_i,
  input  logic [FIELD_W-1:0] blk_e_i,
  input  logic [FIELD_W-1:0] sync_s_i,
  input  logic [FIELD_W-1:0] sync_e_i,
  output logic [FIELD_W-1:0] cnt_o,
  output logic               wrap_o,
  output logic               in_act_o,
  output logic               in_blk_o,
  output logic               in_sync_o
);
  logic [FIELD_W-1:0] cnt_q;

  // >= so a shrunk total applied mid-line still wraps
  assign wrap_o = en_i && step_i && (cnt_q >= tot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= (cnt_q >= tot_i) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign in_act_o  = cnt_q <= act_i;
  assign in_blk_o  = (cnt_q > blk_s_i) && (cnt_q <= blk_e_i);
  assign in_sync_o = (cnt_q > sync_s_i) && (cnt_q <= sync_e_i);

  assert_wrap_to_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));

  assert_hold_without_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> (cnt_q == $past(cnt_q)));

  assert_cleared_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/dtg_out.sv
module dtg_out import disp_timing_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       hpol_i,
  input  logic       vpol_i,
  input  logic [2:0] mode_i,
  input  logic       h_act_i,
  input  logic       h_blk_i,
  input  logic       h_sync_i,
  input  logic       v_act_i,
  input  logic       v_blk_i,
  input  logic       v_sync_i,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       blank_o,
  output logic       active_o,
  output logic       dac_pd_o
);
  logic force_blk, hs_en, vs_en, hs_raw, vs_raw;

  always_comb begin
    case (mode_i)
      PM_ON:    begin force_blk = 1'b0; hs_en = 1'b1; vs_en = 1'b1; end
      PM_BLANK: begin force_blk = 1'b1; hs_en = 1'b1; vs_en = 1'b1; end
      PM_NO_VS: begin force_blk = 1'b1; hs_en = 1'b1; vs_en = 1'b0; end
      PM_NO_HS: begin force_blk = 1'b1; hs_en = 1'b0; vs_en = 1'b1; end
      default:  begin force_blk = 1'b1; hs_en = 1'b0; vs_en = 1'b0; end
    endcase
  end

  assign hs_raw   = en_i && hs_en && h_sync_i;
  assign vs_raw   = en_i && vs_en && v_sync_i;
  assign hsync_o  = hpol_i ? hs_raw : !hs_raw;
  assign vsync_o  = vpol_i ? vs_raw : !vs_raw;
  assign blank_o  = en_i && (force_blk || h_blk_i || v_blk_i);
  assign active_o = en_i && !force_blk && h_act_i && v_act_i;
  assign dac_pd_o = !(hs_en && vs_en);

  assert_off_mode_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= 3'd4) |-> ((hsync_o != hpol_i) && (vsync_o != vpol_i) && (blank_o == en_i)));

  assert_dac_pd_sync_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_pd_o |-> ((hsync_o != hpol_i) || (vsync_o != vpol_i)));

  assert_idle_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!active_o && !blank_o && (hsync_o != hpol_i) && (vsync_o != vpol_i)));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen import disp_timing_pkg::*; #(
  parameter int unsigned       DATA_W     = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 'h4758,
  localparam int unsigned      FIELD_W    = DATA_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [FIELD_W-1:0] hcount_o,
  output logic [FIELD_W-1:0] vcount_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               blank_o,
  output logic               active_o,
  output logic               dac_pd_o
);
  logic [NTIM-1:0][DATA_W-1:0] tim;
  logic                        en, hpol, vpol;
  logic [2:0]                  mode;
  logic [1:0]                  step, wrap, in_act, in_blk, in_sync;
  logic [1:0][FIELD_W-1:0]     cnt;

  assign step = {wrap[0], 1'b1};

  dtg_regs #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .frame_end_i(wrap[1]), .tim_o(tim),
    .en_o(en), .hpol_o(hpol), .vpol_o(vpol), .mode_o(mode)
  );

  // axis 0 = horizontal (words 0..2), axis 1 = vertical (words 3..5)
  for (genvar g = 0; g < 2; g++) begin : g_axis
    localparam int unsigned B = 3 * g;
    dtg_axis #(.FIELD_W(FIELD_W)) u_axis (
      .clk_i, .rst_ni,
      .en_i(en), .step_i(step[g]),
      .tot_i   (tim[B][DATA_W-1:FIELD_W]),
      .act_i   (tim[B][FIELD_W-1:0]),
      .blk_s_i (tim[B+1][FIELD_W-1:0]),
      .blk_e_i (tim[B+1][DATA_W-1:FIELD_W]),
      .sync_s_i(tim[B+2][FIELD_W-1:0]),
      .sync_e_i(tim[B+2][DATA_W-1:FIELD_W]),
      .cnt_o(cnt[g]), .wrap_o(wrap[g]),
      .in_act_o(in_act[g]), .in_blk_o(in_blk[g]), .in_sync_o(in_sync[g])
    );
  end

  dtg_out u_out (
    .clk_i, .rst_ni,
    .en_i(en), .hpol_i(hpol), .vpol_i(vpol), .mode_i(mode),
    .h_act_i(in_act[0]), .h_blk_i(in_blk[0]), .h_sync_i(in_sync[0]),
    .v_act_i(in_act[1]), .v_blk_i(in_blk[1]), .v_sync_i(in_sync[1]),
    .hsync_o, .vsync_o, .blank_o, .active_o, .dac_pd_o
  );

  assign hcount_o = cnt[0];
  assign vcount_o = cnt[1];
endmodule

// File: tb/sim_disp_timing_gen.sv
module sim_disp_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h0000_4758;

  // {mode[2:0], hs_en, vs_en, forced_blank, dac_pd}
  localparam logic [6:0] MODES [6] = '{
    {3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd3, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd4, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd7, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] hcount_o, vcount_o;
  logic        hsync_o, vsync_o, blank_o, active_o, dac_pd_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit en_b = 0, hp_b = 0, vp_b = 0;
  int h_ae = 3, h_te = 7, h_bs = 3, h_be = 7, h_ss = 4, h_se = 6;
  int v_ae = 2, v_te = 5, v_bs = 2, v_be = 5, v_ss = 3, v_se = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_timing_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .hcount_o, .vcount_o, .hsync_o, .vsync_o, .blank_o, .active_o, .dac_pd_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic set_ctrl(input bit en, input bit hp, input bit vp, input bit imm, input logic [2:0] m);
    wr(3'd1, {25'd0, m, imm, vp, hp, en});
    en_b = en; hp_b = hp; vp_b = vp;
  endtask

  // {hsync, vsync, blank, active, dac}
  function automatic logic [4:0] model(int h, int v, bit hse, bit vse, bit fb, bit dac);
    bit hs_w, vs_w, hs, vs, bl, ac;
    hs_w = en_b && hse && h > h_ss && h <= h_se;
    vs_w = en_b && vse && v > v_ss && v <= v_se;
    hs = hp_b ? hs_w : !hs_w;
    vs = vp_b ? vs_w : !vs_w;
    bl = en_b && (fb || (h > h_bs && h <= h_be) || (v > v_bs && v <= v_be));
    ac = en_b && !fb && h <= h_ae && v <= v_ae;
    return {hs, vs, bl, ac, dac};
  endfunction

  task automatic scan(input int n, input logic [6:0] row);
    int ph, pv, h, v, eh, ev;
    logic [4:0] e;
    ph = -1; pv = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h = hcount_o; v = vcount_o;
      e = model(h, v, row[3], row[2], row[1], row[0]);
      chk("R7 hsync", hsync_o, e[4]);
      chk("R7 vsync", vsync_o, e[3]);
      chk("R6 blank", blank_o, e[2]);
      chk("R5 active", active_o, e[1]);
      chk("R9 dac_pd", dac_pd_o, e[0]);
      if (ph >= 0) begin
        eh = (ph == h_te) ? 0 : ph + 1;
        ev = (ph == h_te) ? ((pv == v_te) ? 0 : pv + 1) : pv;
        chk("R4 hcount", h, eh);
        chk("R4 vcount", v, ev);
      end
      ph = h; pv = v;
    end
  endtask

  initial begin
    int mx;
    // R1 reset state
    repeat (2) @(negedge clk);
    addr = 3'd0; #1;
    chk("R1 lock read", rdata, 0);
    chk("R1 hcount", hcount_o, 0);
    chk("R1 vcount", vcount_o, 0);
    chk("R1 hsync", hsync_o, 1);
    chk("R1 vsync", vsync_o, 1);
    chk("R1 blank", blank_o, 0);
    chk("R1 active", active_o, 0);
    chk("R1 dac_pd", dac_pd_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 locked writes dropped
    wr(3'd2, {16'd7, 16'd3});
    rd_chk(3'd2, 0, "R2 locked write");
    wr(3'd1, 32'h1);
    rd_chk(3'd1, 0, "R2 locked ctrl");
    wr(3'd0, KEY);
    rd_chk(3'd0, 1, "R2 unlocked");

    // R3 program and read back
    wr(3'd2, {16'd7, 16'd3});
    wr(3'd3, {16'd7, 16'd3});
    wr(3'd4, {16'd6, 16'd4});
    wr(3'd5, {16'd5, 16'd2});
    wr(3'd6, {16'd5, 16'd2});
    wr(3'd7, {16'd4, 16'd3});
    rd_chk(3'd2, {16'd7, 16'd3}, "R3 h active");
    rd_chk(3'd4, {16'd6, 16'd4}, "R3 h sync");
    rd_chk(3'd7, {16'd4, 16'd3}, "R3 v sync");

    // R2 wrong key relocks
    wr(3'd0, 32'h0000_1234);
    rd_chk(3'd0, 0, "R2 relocked");
    wr(3'd2, 32'hdead_beef);
    rd_chk(3'd2, {16'd7, 16'd3}, "R2 write after relock");
    wr(3'd0, KEY);

    // R4-R7 two frames, active-high syncs
    set_ctrl(1, 1, 1, 0, 3'd0);
    rd_chk(3'd1, 32'h07, "R3 ctrl");
    scan(96, MODES[0]);
    // R7 active-low syncs
    set_ctrl(1, 0, 0, 0, 3'd0);
    scan(48, MODES[0]);

    // R8/R9 power mode table
    for (int r = 0; r < 6; r++) begin
      set_ctrl(1, 1, 1, 0, MODES[r][6:4]);
      scan(48, MODES[r]);
    end
    set_ctrl(1, 1, 1, 0, 3'd0);

    // R11 deferred total change
    while (vcount_o != 1) @(negedge clk);
    wr(3'd2, {16'd9, 16'd3});
    mx = 0;
    while (vcount_o != 0) begin
      @(negedge clk);
      if (vcount_o != 0 && hcount_o > mx) mx = hcount_o;
    end
    chk("R11 old total kept", mx, 7);
    mx = 0;
    while (vcount_o == 0) begin
      if (hcount_o > mx) mx = hcount_o;
      @(negedge clk);
    end
    chk("R11 new total at frame start", mx, 9);

    // R11 immediate update
    set_ctrl(1, 1, 1, 1, 3'd0);
    while (vcount_o != 1) @(negedge clk);
    wr(3'd2, {16'd7, 16'd3});
    @(negedge clk);
    mx = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hcount_o > mx) mx = hcount_o;
    end
    chk("R11 immediate total", mx, 7);

    // R10 disable
    set_ctrl(0, 1, 1, 0, 3'd0);
    @(negedge clk);
    chk("R10 hcount", hcount_o, 0);
    chk("R10 vcount", vcount_o, 0);
    chk("R10 hsync", hsync_o, 0);
    chk("R10 vsync", vsync_o, 0);
    chk("R10 blank", blank_o, 0);
    chk("R10 active", active_o, 0);
    repeat (5) @(negedge clk);
    chk("R10 hcount held", hcount_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule